// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits between a host and a parallel NOR flash array built from two 16-bit devices side by side on a 32-bit bus. The host asks for one of two operations: programming a single 32-bit word, or erasing a run of sectors. The block then produces the bus traffic the devices need. It sends a short unlock preamble followed by the command write. For a program it also sends the data write. It then polls the array until the operation has finished, has failed, or has run out of time.

Each command byte is copied into both 16-bit lanes. Command offsets are word indices, so the byte address on the bus is four times the offset.

A program is treated as finished once two back-to-back reads of the target word agree. An erase is finished once the status word read at byte address 0 shows all of its completion bits. All delays and timeouts are counted in ticks of a prescaler, and one tick lasts `TICK_DIV` clock cycles.

The flash port is a plain synchronous strobe interface. A write lasts one cycle with its address and data valid in that cycle. Read data is sampled exactly `READ_LAT` cycles after the read strobe.

Top module: `norSequencer`

## Requirements
- R1: After reset, `hostBusy`, `hostDone`, `hostErr`, `memWrEn` and `memRdEn` are all low.
- R2: A request is taken only while `hostBusy` is low, and a request made while busy has no effect. From the cycle after acceptance, `hostBusy` stays high until the operation ends. At that point `hostDone` or `hostErr` (never both) pulses for one cycle while `hostBusy` is low.
- R3: A program (`hostOp`=0) issues four single-cycle writes in this order: 0x00AA00AA to byte address 0x1554, 0x00550055 to 0x0AA8, 0x00A000A0 to 0x1554, and `hostData` to `hostAddr`.
- R4: After the last program write, no read is issued until at least `PROG_DELAY` ticks have passed.
- R5: Program polling reads `hostAddr`. It always makes at least three reads and stops as soon as the two most recent reads are equal. From the third read onward, consecutive reads are at least `POLL_PAUSE` ticks apart, while the first three reads follow each other without a pause.
- R6: Program polling stops after `POLL_LIMIT` reads even if the values never settle.
- R7: When program polling stops, a final read equal to the written word gives `hostDone`. Any other final read causes one write of 0x00F000F0 to `hostAddr`, followed by `hostErr`.
- R8: An erase (`hostOp`=1, `hostData` = length in bytes) issues six writes for each sector, in this order: 0x00AA00AA@0x1554, 0x00550055@0x0AA8, 0x00800080@0x1554, 0x00AA00AA@0x1554, 0x00550055@0x0AA8, and 0x00300030 to the sector address.
- R9: Erase polling reads byte address 0. A sector is complete when the read value has every bit of 0x80808080 set. Multi-sector erases then continue with the sector 2^`SECTOR_SHIFT` bytes higher, and `hostDone` follows the last sector.
- R10: A sector whose status is not complete `ERASE_TIMEOUT` ticks after its final command write ends the operation with `hostErr`. No reset write is issued, and the block is ready again.
- R11: An erase whose address or length has any of the low `SECTOR_SHIFT` bits set, or whose end passes 2^`ADDR_W` bytes, is rejected. `hostErr` pulses in the cycle after the request, `hostBusy` stays low and no bus cycle is issued. A zero-length erase likewise gives `hostDone` at once with no bus cycle. An erase ending exactly at 2^`ADDR_W` is accepted.
- R12: `memWrEn` and `memRdEn` are never high together, and are only high while busy. Read data is taken from the cycle `READ_LAT` cycles after `memRdEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | Request strobe, sampled when idle |
| hostOp | input | 1 | 0 = program word, 1 = erase sectors |
| hostAddr | input | ADDR_W | Byte address of target word or first sector |
| hostData | input | 32 | Program data, or erase length in bytes |
| hostBusy | output | 1 | Operation in progress |
| hostDone | output | 1 | One-cycle success pulse |
| hostErr | output | 1 | One-cycle failure or rejection pulse |
| memAddr | output | ADDR_W | Flash byte address |
| memWrData | output | 32 | Flash write data |
| memWrEn | output | 1 | One-cycle write strobe |
| memRdEn | output | 1 | One-cycle read strobe |
| memRdData | input | 32 | Flash read data, valid READ_LAT cycles after the read strobe |

## Verification
A rejected or zero-length erase is checked for its one-cycle pulse at the first falling edge after the accepting edge. That falling edge is also where `hostBusy` is checked for an accepted request. For longer operations the bench logs every bus strobe together with its cycle number at falling edges. From that log it checks cycle gaps against tick-based lower bounds: the program delay measured from the last write, the polling pause between reads, and the erase timeout measured from the sixth write. The flash model holds each read value valid from `READ_LAT` cycles after the strobe through the next rising edge. A mis-timed capture therefore sees a different value and changes the outcome.

// File: rtl/norSeqPkg.sv
package norSeqPkg;

  typedef enum logic {OP_PROG = 1'b0, OP_ERASE = 1'b1} seqOp_t;

  typedef enum logic [2:0] {
    S_IDLE, S_WRITE, S_PDELAY, S_RD_ISSUE, S_RD_WAIT, S_EVAL, S_PAUSE, S_RESET_WR
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic       wrStb;
    logic [2:0] wrIdx;
    logic       rstStb;
    logic       rdStb;
    logic       capture;
    logic       dlyClr;
    logic       pollClr;
    logic       nextSector;
  } seqStrobe_t;

  typedef struct packed {
    logic        useTarget;
    logic        useData;
    logic [11:0] wordOfs;
    logic [7:0]  code;
  } busCmd_t;

  localparam logic [31:0] ERASE_DONE_MASK = 32'h8080_8080;
  localparam logic [7:0]  CODE_RESET      = 8'hF0;

  function automatic logic [31:0] laneCode(input logic [7:0] c);
    return {8'h00, c, 8'h00, c};
  endfunction

  function automatic busCmd_t cmdFor(input seqOp_t op, input logic [2:0] idx);
    busCmd_t r;
    r = '{useTarget: 1'b0, useData: 1'b0, wordOfs: 12'h555, code: 8'hAA};
    case (idx)
      3'd1: begin r.wordOfs = 12'h2AA; r.code = 8'h55; end
      3'd2: r.code = (op == OP_PROG) ? 8'hA0 : 8'h80;
      3'd3: if (op == OP_PROG) begin r.useTarget = 1'b1; r.useData = 1'b1; end
      3'd4: begin r.wordOfs = 12'h2AA; r.code = 8'h55; end
      3'd5: begin r.useTarget = 1'b1; r.code = 8'h30; end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/norSeqPath.sv
module norSeqPath
  import norSeqPkg::*;
#(
  parameter int ADDR_W       = 24,
  parameter int SECTOR_SHIFT = 17,
  parameter int TICK_DIV     = 4,
  parameter int READ_LAT     = 2,
  parameter int DLY_W        = 8,
  parameter int CNT_W        = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        st,
  input  logic              hostOp,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostData,
  input  logic [31:0]       memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWrData,
  output logic              memWrEn,
  output logic              memRdEn,
  output seqOp_t            opQ,
  output logic              eraseBad,
  output logic              eraseZero,
  output logic              lastSector,
  output logic [DLY_W-1:0]  dlyCnt,
  output logic [CNT_W-1:0]  readCnt,
  output logic              stable,
  output logic              match,
  output logic              statusOk,
  output logic              latDone
);
  localparam int SEC_W = ADDR_W - SECTOR_SHIFT + 1;
  localparam int LAT_W = $clog2(READ_LAT + 1);
  localparam logic [32:0] DEV_END = 33'(1) << ADDR_W;
  localparam logic [ADDR_W-1:0] SECTOR_STEP = ADDR_W'(1) << SECTOR_SHIFT;

  logic [ADDR_W-1:0] addrQ;
  logic [31:0]       dataQ, lastQ, prevQ;
  logic [SEC_W-1:0]  sectorsQ;
  logic [LAT_W-1:0]  latCnt;
  logic [32:0]       endSum;
  logic              tick;
  busCmd_t           cmd;

  // request validation
  always_comb begin
    endSum    = 33'(hostAddr) + 33'(hostData);
    eraseBad  = (|hostAddr[SECTOR_SHIFT-1:0]) || (|hostData[SECTOR_SHIFT-1:0]) ||
                (endSum > DEV_END);
    eraseZero = (hostData == 32'd0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ <= OP_PROG; addrQ <= '0; dataQ <= '0; sectorsQ <= '0;
    end else if (st.load) begin
      opQ      <= seqOp_t'(hostOp);
      addrQ    <= hostAddr;
      dataQ    <= hostData;
      sectorsQ <= hostData[SECTOR_SHIFT +: SEC_W];
    end else if (st.nextSector) begin
      addrQ    <= addrQ + SECTOR_STEP;
      sectorsQ <= sectorsQ - 1'b1;
    end
  end

  // tick prescaler variant chosen by parameter
  generate
    if (TICK_DIV == 1) begin : g_noPresc
      assign tick = 1'b1;
    end else begin : g_presc
      localparam int PW = $clog2(TICK_DIV);
      logic [PW-1:0] prescQ;
      always_ff @(posedge clk) begin
        if (!rstN || st.dlyClr) prescQ <= '0;
        else if (prescQ == PW'(TICK_DIV - 1)) prescQ <= '0;
        else prescQ <= prescQ + 1'b1;
      end
      assign tick = (prescQ == PW'(TICK_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN || st.dlyClr) dlyCnt <= '0;
    else if (tick && dlyCnt != '1) dlyCnt <= dlyCnt + 1'b1;
  end

  // read latency counter and capture
  always_ff @(posedge clk) begin
    if (!rstN) latCnt <= '0;
    else if (st.rdStb) latCnt <= LAT_W'(1);
    else if (st.capture) latCnt <= '0;
    else if (latCnt != '0 && latCnt != LAT_W'(READ_LAT)) latCnt <= latCnt + 1'b1;
  end
  assign latDone = (latCnt == LAT_W'(READ_LAT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastQ <= '0; prevQ <= '0; readCnt <= '0;
    end else if (st.pollClr) begin
      readCnt <= '0;
    end else if (st.capture) begin
      lastQ <= memRdData;
      prevQ <= lastQ;
      if (readCnt != '1) readCnt <= readCnt + 1'b1;
    end
  end

  assign stable     = (readCnt >= CNT_W'(3)) && (lastQ == prevQ);
  assign match      = (lastQ == dataQ);
  assign statusOk   = ((lastQ & ERASE_DONE_MASK) == ERASE_DONE_MASK);
  assign lastSector = (sectorsQ == SEC_W'(1));

  // bus port
  always_comb begin
    cmd       = cmdFor(opQ, st.wrIdx);
    memWrEn   = st.wrStb | st.rstStb;
    memRdEn   = st.rdStb;
    memAddr   = addrQ;
    memWrData = dataQ;
    if (st.rstStb) begin
      memWrData = laneCode(CODE_RESET);
    end else if (st.wrStb) begin
      if (!cmd.useTarget) memAddr = ADDR_W'({cmd.wordOfs, 2'b00});
      if (!cmd.useData)   memWrData = laneCode(cmd.code);
    end else if (st.rdStb && opQ == OP_ERASE) begin
      memAddr = '0;
    end
  end

  assert_no_rw_overlap_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrEn && memRdEn));
  assert_capture_on_latency_R12: assert property (@(posedge clk) disable iff (!rstN)
    st.capture |-> latDone);
  assert_read_wait_R12: assert property (@(posedge clk) disable iff (!rstN)
    st.rdStb |=> !latDone || (READ_LAT == 1));

endmodule

// File: rtl/norSeqCtrl.sv
module norSeqCtrl
  import norSeqPkg::*;
#(
  parameter int PROG_DELAY    = 128,
  parameter int POLL_PAUSE    = 10,
  parameter int POLL_LIMIT    = 10000,
  parameter int ERASE_TIMEOUT = 200,
  parameter int DLY_W         = 8,
  parameter int CNT_W         = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostReq,
  input  logic             hostOp,
  input  seqOp_t           opQ,
  input  logic             eraseBad,
  input  logic             eraseZero,
  input  logic             lastSector,
  input  logic [DLY_W-1:0] dlyCnt,
  input  logic [CNT_W-1:0] readCnt,
  input  logic             stable,
  input  logic             match,
  input  logic             statusOk,
  input  logic             latDone,
  output seqStrobe_t       st,
  output logic             busy,
  output logic             doneQ,
  output logic             errQ
);
  localparam logic [DLY_W-1:0] PD_LIM = DLY_W'(PROG_DELAY);
  localparam logic [DLY_W-1:0] PP_LIM = DLY_W'(POLL_PAUSE);
  localparam logic [DLY_W-1:0] ET_LIM = DLY_W'(ERASE_TIMEOUT);
  localparam logic [CNT_W-1:0] PL_LIM = CNT_W'(POLL_LIMIT);

  seqState_t stateQ, stateD;
  logic [2:0] idxQ, idxD;
  logic doneD, errD;
  logic [2:0] lastIdx;

  assign lastIdx = (opQ == OP_PROG) ? 3'd3 : 3'd5;
  assign busy    = (stateQ != S_IDLE);

  always_comb begin
    st     = '0;
    stateD = stateQ;
    idxD   = idxQ;
    doneD  = 1'b0;
    errD   = 1'b0;
    st.wrIdx = idxQ;
    case (stateQ)
      S_IDLE: if (hostReq) begin
        st.load = 1'b1;
        idxD    = 3'd0;
        if (hostOp == OP_ERASE && eraseBad)       errD = 1'b1;
        else if (hostOp == OP_ERASE && eraseZero) doneD = 1'b1;
        else                                      stateD = S_WRITE;
      end
      S_WRITE: begin
        st.wrStb = 1'b1;
        if (idxQ == lastIdx) begin
          st.dlyClr  = 1'b1;
          st.pollClr = 1'b1;
          stateD = (opQ == OP_PROG) ? S_PDELAY : S_RD_ISSUE;
        end else begin
          idxD = idxQ + 3'd1;
        end
      end
      S_PDELAY:   if (dlyCnt >= PD_LIM) stateD = S_RD_ISSUE;
      S_RD_ISSUE: begin st.rdStb = 1'b1; stateD = S_RD_WAIT; end
      S_RD_WAIT:  if (latDone) begin st.capture = 1'b1; stateD = S_EVAL; end
      S_EVAL: begin
        if (opQ == OP_PROG) begin
          if (stable || readCnt >= PL_LIM) begin
            if (match) begin doneD = 1'b1; stateD = S_IDLE; end
            else stateD = S_RESET_WR;
          end else if (readCnt >= CNT_W'(3)) begin
            st.dlyClr = 1'b1;
            stateD = S_PAUSE;
          end else begin
            stateD = S_RD_ISSUE;
          end
        end else begin
          if (statusOk) begin
            if (lastSector) begin doneD = 1'b1; stateD = S_IDLE; end
            else begin st.nextSector = 1'b1; idxD = 3'd0; stateD = S_WRITE; end
          end else if (dlyCnt >= ET_LIM) begin
            errD = 1'b1; stateD = S_IDLE;
          end else begin
            stateD = S_RD_ISSUE;
          end
        end
      end
      S_PAUSE:    if (dlyCnt >= PP_LIM) stateD = S_RD_ISSUE;
      S_RESET_WR: begin st.rstStb = 1'b1; errD = 1'b1; stateD = S_IDLE; end
      default:    stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE; idxQ <= '0; doneQ <= 1'b0; errQ <= 1'b0;
    end else begin
      stateQ <= stateD; idxQ <= idxD; doneQ <= doneD; errQ <= errD;
    end
  end

  assert_pulse_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(doneQ && errQ));
  assert_pulse_when_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ || errQ) |-> !busy);
  assert_accept_on_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(hostReq));
  assert_read_before_delay_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_PDELAY && st.rdStb) |-> 1'b0);

endmodule

// File: rtl/norSequencer.sv
module norSequencer
  import norSeqPkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int SECTOR_SHIFT  = 17,
  parameter int TICK_DIV      = 4,
  parameter int READ_LAT      = 2,
  parameter int PROG_DELAY    = 128,
  parameter int POLL_PAUSE    = 10,
  parameter int POLL_LIMIT    = 10000,
  parameter int ERASE_TIMEOUT = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostOp,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostData,
  output logic              hostBusy,
  output logic              hostDone,
  output logic              hostErr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWrData,
  output logic              memWrEn,
  output logic              memRdEn,
  input  logic [31:0]       memRdData
);
  localparam int DLY_MAX0 = (PROG_DELAY > POLL_PAUSE) ? PROG_DELAY : POLL_PAUSE;
  localparam int DLY_MAX  = (DLY_MAX0 > ERASE_TIMEOUT) ? DLY_MAX0 : ERASE_TIMEOUT;
  localparam int DLY_W    = $clog2(DLY_MAX + 2);
  localparam int CNT_W    = $clog2(POLL_LIMIT + 2);

  seqStrobe_t       st;
  seqOp_t           opQ;
  logic             eraseBad, eraseZero, lastSector, stable, match, statusOk, latDone;
  logic [DLY_W-1:0] dlyCnt;
  logic [CNT_W-1:0] readCnt;

  norSeqCtrl #(
    .PROG_DELAY(PROG_DELAY), .POLL_PAUSE(POLL_PAUSE), .POLL_LIMIT(POLL_LIMIT),
    .ERASE_TIMEOUT(ERASE_TIMEOUT), .DLY_W(DLY_W), .CNT_W(CNT_W)
  ) ctrl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostOp(hostOp), .opQ(opQ),
    .eraseBad(eraseBad), .eraseZero(eraseZero), .lastSector(lastSector),
    .dlyCnt(dlyCnt), .readCnt(readCnt), .stable(stable), .match(match),
    .statusOk(statusOk), .latDone(latDone), .st(st), .busy(hostBusy),
    .doneQ(hostDone), .errQ(hostErr)
  );

  norSeqPath #(
    .ADDR_W(ADDR_W), .SECTOR_SHIFT(SECTOR_SHIFT), .TICK_DIV(TICK_DIV),
    .READ_LAT(READ_LAT), .DLY_W(DLY_W), .CNT_W(CNT_W)
  ) path (
    .clk(clk), .rstN(rstN), .st(st), .hostOp(hostOp), .hostAddr(hostAddr),
    .hostData(hostData), .memRdData(memRdData), .memAddr(memAddr),
    .memWrData(memWrData), .memWrEn(memWrEn), .memRdEn(memRdEn), .opQ(opQ),
    .eraseBad(eraseBad), .eraseZero(eraseZero), .lastSector(lastSector),
    .dlyCnt(dlyCnt), .readCnt(readCnt), .stable(stable), .match(match),
    .statusOk(statusOk), .latDone(latDone)
  );

  assert_bus_only_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn || memRdEn) |-> hostBusy);
  assert_reject_no_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    hostErr |-> !hostBusy);

endmodule

// File: tb/norSequencer_test.sv
module norSequencer_test;
  localparam int AW = 24, SS = 17, TD = 2, RL = 2;
  localparam int PDLY = 128, PPAUSE = 10, PLIM = 8, ETO = 50;

  logic clk = 1'b0, rstN = 1'b0;
  logic hostReq = 1'b0, hostOp = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [31:0] hostData = '0;
  logic hostBusy, hostDone, hostErr, memWrEn, memRdEn;
  logic [AW-1:0] memAddr;
  logic [31:0] memWrData, memRdData;

  always #2 clk = ~clk;  // 250 MHz

  norSequencer #(.ADDR_W(AW), .SECTOR_SHIFT(SS), .TICK_DIV(TD), .READ_LAT(RL),
    .PROG_DELAY(PDLY), .POLL_PAUSE(PPAUSE), .POLL_LIMIT(PLIM), .ERASE_TIMEOUT(ETO)) uut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostOp(hostOp), .hostAddr(hostAddr),
    .hostData(hostData), .hostBusy(hostBusy), .hostDone(hostDone), .hostErr(hostErr),
    .memAddr(memAddr), .memWrData(memWrData), .memWrEn(memWrEn), .memRdEn(memRdEn),
    .memRdData(memRdData));

  int nTests = 0, nFail = 0, cyc = 0;
  int wrN = 0, rdN = 0, doneCnt = 0, errCnt = 0, busyCnt = 0;
  logic [AW-1:0] wrAddr [0:63];
  logic [31:0]   wrData [0:63];
  int            wrCyc  [0:63];
  logic [AW-1:0] rdAddr [0:63];
  int            rdCyc  [0:63];
  logic [31:0] script [0:63];
  int scriptLen = 0, readIdx = 0;
  logic [31:0] scriptDef = 32'h0;
  logic [31:0] pipe [0:RL];

  assign memRdData = pipe[RL];

  always @(posedge clk) cyc <= cyc + 1;

  // flash model and bus log, evaluated away from the active edge
  always @(negedge clk) begin
    for (int i = RL; i > 0; i--) pipe[i] <= pipe[i-1];
    if (memRdEn) begin
      pipe[0] <= (readIdx < scriptLen) ? script[readIdx] : scriptDef;
      readIdx <= readIdx + 1;
      if (rdN < 64) begin rdAddr[rdN] <= memAddr; rdCyc[rdN] <= cyc; end
      rdN <= rdN + 1;
    end else pipe[0] <= 32'hDEAD_BEEF;
    if (memWrEn) begin
      if (wrN < 64) begin wrAddr[wrN] <= memAddr; wrData[wrN] <= memWrData; wrCyc[wrN] <= cyc; end
      wrN <= wrN + 1;
    end
    if (hostDone) doneCnt <= doneCnt + 1;
    if (hostErr) errCnt <= errCnt + 1;
    if (hostBusy) busyCnt <= busyCnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clearLogs();
    wrN = 0; rdN = 0; readIdx = 0; doneCnt = 0; errCnt = 0; busyCnt = 0; scriptLen = 0;
  endtask

  task automatic issue(input bit op, input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    hostReq = 1'b1; hostOp = op; hostAddr = a; hostData = d;
    @(negedge clk);
    hostReq = 1'b0;
  endtask

  task automatic waitEnd(output bit gotDone, output bit gotErr, output int endCyc);
    int n = 0;
    while (!(hostDone || hostErr) && n < 5000) begin @(negedge clk); n++; end
    gotDone = hostDone; gotErr = hostErr; endCyc = cyc;
    @(negedge clk);
  endtask

  function automatic logic [31:0] lane(input logic [7:0] c);
    return {8'h00, c, 8'h00, c};
  endfunction

  task automatic checkPreamble(input string req, input int base, input bit erase);
    logic [AW-1:0] ea [0:4];
    logic [7:0]    ec [0:4];
    ea = '{24'h1554, 24'h0AA8, 24'h1554, 24'h1554, 24'h0AA8};
    ec = '{8'hAA, 8'h55, erase ? 8'h80 : 8'hA0, 8'hAA, 8'h55};
    for (int i = 0; i < (erase ? 5 : 3); i++) begin
      chk(wrAddr[base+i] == ea[i], req, "preamble address", 32'(wrAddr[base+i]), 32'(ea[i]));
      chk(wrData[base+i] == lane(ec[i]), req, "preamble data", wrData[base+i], lane(ec[i]));
    end
  endtask

  task automatic testReset();
    chk(!hostBusy && !hostDone && !hostErr, "R1", "host outputs after reset",
        {hostBusy, hostDone, hostErr}, 0);
    chk(!memWrEn && !memRdEn, "R1", "bus strobes after reset", {memWrEn, memRdEn}, 0);
  endtask

  task automatic testProgOk();
    bit d, e; int ec;
    clearLogs();
    script[0] = 32'h1; script[1] = 32'h2; script[2] = 32'h1234_5678; script[3] = 32'h1234_5678;
    scriptLen = 4;
    issue(1'b0, 24'h004010, 32'h1234_5678);
    chk(hostBusy, "R2", "busy after accept", hostBusy, 1);
    waitEnd(d, e, ec);
    chk(d && !e, "R7", "program success pulse", {d, e}, 2'b10);
    chk(wrN == 4, "R3", "program write count", wrN, 4);
    checkPreamble("R3", 0, 1'b0);
    chk(wrAddr[3] == 24'h004010 && wrData[3] == 32'h1234_5678, "R3", "program data write",
        wrData[3], 32'h1234_5678);
    chk(rdCyc[0] - wrCyc[3] >= PDLY * TD, "R4", "program delay cycles", rdCyc[0] - wrCyc[3], PDLY * TD);
    chk(rdN == 4, "R5", "reads until two agree (R12 capture timing)", rdN, 4);
    chk(rdAddr[0] == 24'h004010 && rdAddr[3] == 24'h004010, "R5", "poll address", 32'(rdAddr[3]), 32'h4010);
    chk(rdCyc[1] - rdCyc[0] < PPAUSE * TD, "R5", "no pause before third read", rdCyc[1] - rdCyc[0], PPAUSE * TD);
    chk(rdCyc[3] - rdCyc[2] >= PPAUSE * TD, "R5", "pause after third read", rdCyc[3] - rdCyc[2], PPAUSE * TD);
    chk(doneCnt == 1 && !hostBusy, "R2", "single done pulse", doneCnt, 1);
  endtask

  task automatic testProgMin();
    bit d, e; int ec;
    clearLogs();
    for (int i = 0; i < 3; i++) script[i] = 32'hCAFE_0001;
    scriptLen = 3;
    issue(1'b0, 24'h000100, 32'hCAFE_0001);
    waitEnd(d, e, ec);
    chk(rdN == 3 && d, "R5", "minimum of three reads", rdN, 3);
  endtask

  task automatic testProgMismatch();
    bit d, e; int ec;
    clearLogs();
    script[0] = 32'h5; script[1] = 32'h7; script[2] = 32'h7;
    scriptLen = 3;
    issue(1'b0, 24'h000200, 32'h0000_0009);
    waitEnd(d, e, ec);
    chk(e && !d, "R7", "mismatch gives error", {d, e}, 2'b01);
    chk(wrN == 5 && wrAddr[4] == 24'h000200 && wrData[4] == 32'h00F0_00F0, "R7",
        "reset write after mismatch", wrData[4], 32'h00F0_00F0);
  endtask

  task automatic testProgLimit();
    bit d, e; int ec;
    clearLogs();
    for (int i = 0; i < 16; i++) script[i] = (i % 2 == 0) ? 32'h1 : 32'h2;
    scriptLen = 16;
    issue(1'b0, 24'h000300, 32'h0000_0003);
    waitEnd(d, e, ec);
    chk(rdN == PLIM, "R6", "poll read limit", rdN, PLIM);
    chk(e && wrN == 5 && wrData[4] == 32'h00F0_00F0, "R7", "limit ends with reset and error",
        wrN, 5);
  endtask

  task automatic testEraseOne();
    bit d, e; int ec;
    clearLogs();
    script[0] = 32'h0; script[1] = 32'h8080_0080; script[2] = 32'h8080_8080;
    scriptLen = 3;
    issue(1'b1, 24'h0A0000, 32'h0002_0000);
    waitEnd(d, e, ec);
    chk(d && !e, "R9", "erase success", {d, e}, 2'b10);
    chk(wrN == 6, "R8", "erase write count", wrN, 6);
    checkPreamble("R8", 0, 1'b1);
    chk(wrAddr[5] == 24'h0A0000 && wrData[5] == 32'h0030_0030, "R8", "erase confirm write",
        wrData[5], 32'h0030_0030);
    chk(rdN == 3 && rdAddr[0] == '0 && rdAddr[2] == '0, "R9", "status reads at zero until mask set",
        rdN, 3);
  endtask

  task automatic testEraseTwo();
    bit d, e; int ec;
    clearLogs();
    scriptDef = 32'h8080_8080;
    issue(1'b1, 24'h040000, 32'h0004_0000);
    waitEnd(d, e, ec);
    chk(d && wrN == 12, "R9", "two-sector erase writes", wrN, 12);
    chk(wrAddr[5] == 24'h040000 && wrAddr[11] == 24'h060000, "R9", "second sector address",
        32'(wrAddr[11]), 32'h060000);
    checkPreamble("R8", 6, 1'b1);
    scriptDef = 32'h0;
  endtask

  task automatic testEraseTimeout();
    bit d, e; int ec;
    clearLogs();
    scriptDef = 32'h8080_8000;
    issue(1'b1, 24'h020000, 32'h0002_0000);
    waitEnd(d, e, ec);
    chk(e && !d, "R10", "erase timeout error", {d, e}, 2'b01);
    chk(ec - wrCyc[5] >= ETO * TD, "R10", "timeout not early", ec - wrCyc[5], ETO * TD);
    chk(wrN == 6 && !hostBusy, "R10", "no reset write, ready again", wrN, 6);
    scriptDef = 32'h0;
  endtask

  task automatic testReject(input logic [AW-1:0] a, input logic [31:0] len, input string what);
    clearLogs();
    issue(1'b1, a, len);
    chk(hostErr && !hostBusy, "R11", what, {hostErr, hostBusy}, 2'b10);
    repeat (5) @(negedge clk);
    chk(wrN == 0 && rdN == 0 && busyCnt == 0, "R11", "no bus cycles on reject", wrN + rdN + busyCnt, 0);
  endtask

  task automatic testZeroAndEdge();
    bit d, e; int ec;
    clearLogs();
    issue(1'b1, 24'h020000, 32'h0);
    chk(hostDone && !hostErr && !hostBusy, "R11", "zero length done at once",
        {hostDone, hostErr, hostBusy}, 3'b100);
    repeat (3) @(negedge clk);
    chk(wrN == 0 && busyCnt == 0, "R11", "zero length no bus cycles", wrN, 0);
    clearLogs();
    scriptDef = 32'h8080_8080;
    issue(1'b1, 24'hFE0000, 32'h0002_0000);
    waitEnd(d, e, ec);
    chk(d && wrN == 6, "R11", "erase ending at device end accepted", wrN, 6);
    scriptDef = 32'h0;
  endtask

  task automatic testIgnoreBusy();
    bit d, e; int ec;
    clearLogs();
    for (int i = 0; i < 3; i++) script[i] = 32'h0000_ABCD;
    scriptLen = 3;
    issue(1'b0, 24'h000400, 32'h0000_ABCD);
    repeat (20) @(negedge clk);
    hostReq = 1'b1; hostOp = 1'b1; hostAddr = 24'h0; hostData = 32'h0002_0000;
    @(negedge clk);
    hostReq = 1'b0;
    waitEnd(d, e, ec);
    repeat (40) @(negedge clk);
    chk(d && wrN == 4 && errCnt == 0 && doneCnt == 1 && !hostBusy, "R2",
        "request while busy ignored", wrN, 4);
  endtask

  initial begin
    for (int i = 0; i <= RL; i++) pipe[i] = '0;
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testProgOk();
    testProgMin();
    testProgMismatch();
    testProgLimit();
    testEraseOne();
    testEraseTwo();
    testEraseTimeout();
    testReject(24'h001000, 32'h0002_0000, "misaligned address rejected");
    testReject(24'h020000, 32'h0001_0000, "misaligned length rejected");
    testReject(24'hFE0000, 32'h0004_0000, "erase past end rejected");
    testZeroAndEdge();
    testIgnoreBusy();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    nTests++; nFail++;
    $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule